// File: doc/BRIEF.md
# Sector ECC Syndrome Checker and Single-Bit Locator

This block checks one 512-byte sector against its 24-bit Hamming-style parity code. The code held in the flash spare area (the stored code) and the code computed while the sector streamed past (the computed code) are presented together with a one-cycle start strobe. Both codes are rearranged into interleaved even/odd parity order and XORed, which gives a 24-bit syndrome. The population count of that syndrome decides the outcome.

One clock after the strobe the block presents a registered verdict and a one-cycle done pulse. For a clean sector the verdict is clean. For a single flipped data bit it is fixed, together with the 9-bit byte offset inside the sector and an 8-bit one-hot mask; the caller XORs that mask into the byte at that offset. For anything else it is fatal. A freshly erased page, whose spare area reads as all ones while the computed code is all zeros, is reported as clean rather than fatal. The verdict and location are held until the next strobe.

Code bytes are packed low byte first: bits 7:0 are byte 0, bits 15:8 are byte 1 and bits 23:16 are byte 2. Byte 0 holds the even parities of the eight low address levels, with bit k for level k. Byte 1 holds the odd parities of those same levels. Byte 2 bits 3:0 hold the even parities of levels 8 to 11, and bits 7:4 hold their odd parities. Levels 0 to 2 address the bit within a byte; levels 3 to 11 address the byte.

Top module: `ecc_sector_fixer`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0, status_o is 2'b00, fix_offset_o is 0 and fix_mask_o is 0 until the first strobe.
- R2: done_o is 1 for exactly the one cycle after a cycle with start_i high, and 0 after every cycle with start_i low.
- R3: Equal stored and computed codes give status 2'b00 (clean) with fix_offset_o = 0 and fix_mask_o = 0.
- R4: A syndrome with exactly 12 ones gives status 2'b01 (fixed). fix_offset_o is built from the odd-parity syndrome bits of levels 11 down to 3, most significant first. fix_mask_o is the value 1 shifted left by the bit index, and the bit index is built from the odd-parity syndrome bits of levels 2 down to 0.
- R5: A syndrome with exactly one 1 gives status 2'b10 (fatal).
- R6: A syndrome with exactly eleven 1s gives status 2'b10 (fatal).
- R7: Any other nonzero count, such as 2 or 23, gives status 2'b10 (fatal), unless R8 applies.
- R8: A stored code of 24'hFFFFFF with a computed code of 24'h000000 gives status 2'b00.
- R9: A stored code of 24'hFFFFFF with a nonzero computed code is not exempt, and a count other than 0 or 12 gives status 2'b10.
- R10: With start_i low, status_o, fix_offset_o and fix_mask_o keep their values whatever the code inputs do. Whenever status is not 2'b01, fix_offset_o and fix_mask_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | One-cycle strobe: evaluate the codes on the inputs |
| stored_code_i | input | 24 | Code read from the spare area |
| calc_code_i | input | 24 | Code computed over the sector data |
| done_o | output | 1 | One-cycle pulse: verdict updated |
| status_o | output | 2 | 00 clean, 01 fixed, 10 fatal |
| fix_offset_o | output | 9 | Byte offset of the flipped bit |
| fix_mask_o | output | 8 | One-hot mask to XOR into that byte |

## Verification
A wrong unpacking permutation or a wrong syndrome bit order shows up on the first single-bit case: the offset or the mask comes out wrong, or the count no longer reaches 12 and the verdict turns fatal. The bench builds its single-bit stimuli from the address of the flipped bit, so a transposed level is caught one cycle after the strobe. A wrong enable on the result registers shows as a verdict that changes without a done pulse, which the hold checks look for between strobes. A wrong erased-page exemption shows as a wrong verdict on the all-ones stored code cases.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int SECTOR_BYTES = 512;
  localparam int BIT_W        = 3;                       // bit-in-byte address levels
  localparam int OFS_W        = $clog2(SECTOR_BYTES);    // byte address levels
  localparam int LEVELS       = OFS_W + BIT_W;           // parity pairs
  localparam int SYN_W        = 2 * LEVELS;              // syndrome bits
  localparam int CODE_W       = 24;                      // packed code bits
  localparam int LOW_LEVELS   = 8;                       // levels held in bytes 0 and 1
  localparam int CNT_W        = $clog2(SYN_W + 1);
  localparam int MASK_W       = 1 << BIT_W;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'b00,
    ECC_FIXED = 2'b01,
    ECC_FATAL = 2'b10
  } ecc_stat_e;
endpackage

// File: rtl/ecc_code_unpack.sv
module ecc_code_unpack
  import ecc_fix_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [SYN_W-1:0]  par_o    // [2k] even, [2k+1] odd of level k
);
  localparam int HI_LEVELS = LEVELS - LOW_LEVELS;

  for (genvar k = 0; k < LEVELS; k++) begin : g_level
    if (k < LOW_LEVELS) begin : g_low
      assign par_o[2*k]   = code_i[k];
      assign par_o[2*k+1] = code_i[LOW_LEVELS + k];
    end else begin : g_high
      assign par_o[2*k]   = code_i[2*LOW_LEVELS + (k - LOW_LEVELS)];
      assign par_o[2*k+1] = code_i[2*LOW_LEVELS + HI_LEVELS + (k - LOW_LEVELS)];
    end
  end
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
  import ecc_fix_pkg::*;
(
  input  logic [SYN_W-1:0] syn_i,
  input  logic             erased_i,  // stored all ones and computed all zeros
  output ecc_stat_e        stat_o
);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < SYN_W; i++) begin
      ones = ones + CNT_W'(syn_i[i]);
    end
  end

  always_comb begin
    if (ones == '0) begin
      stat_o = ECC_CLEAN;
    end else if (ones == CNT_W'(LEVELS)) begin
      stat_o = ECC_FIXED;
    end else if (ones == CNT_W'(1) || ones == CNT_W'(LEVELS - 1)) begin
      stat_o = ECC_FATAL;
    end else if (erased_i) begin
      stat_o = ECC_CLEAN;
    end else begin
      stat_o = ECC_FATAL;
    end
  end
endmodule

// File: rtl/ecc_error_locate.sv
module ecc_error_locate
  import ecc_fix_pkg::*;
(
  input  logic [SYN_W-1:0]  syn_i,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [MASK_W-1:0] mask_o
);
  logic [BIT_W-1:0] bit_idx;

  for (genvar j = 0; j < BIT_W; j++) begin : g_bit
    assign bit_idx[j] = syn_i[2*j + 1];
  end

  for (genvar j = 0; j < OFS_W; j++) begin : g_ofs
    assign ofs_o[j] = syn_i[2*(j + BIT_W) + 1];
  end

  assign mask_o = MASK_W'(1) << bit_idx;
endmodule

// File: rtl/ecc_sector_fixer.sv
module ecc_sector_fixer
  import ecc_fix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] stored_code_i,
  input  logic [23:0] calc_code_i,
  output logic        done_o,
  output logic [1:0]  status_o,
  output logic [8:0]  fix_offset_o,
  output logic [7:0]  fix_mask_o
);
  logic [SYN_W-1:0]  par_stored, par_calc, syn;
  logic              erased;
  ecc_stat_e         stat_d, stat_q;
  logic [OFS_W-1:0]  ofs_raw, ofs_d, ofs_q;
  logic [MASK_W-1:0] mask_raw, mask_d, mask_q;
  logic              done_q;

  ecc_code_unpack i_unpack_stored (.code_i(stored_code_i), .par_o(par_stored));
  ecc_code_unpack i_unpack_calc   (.code_i(calc_code_i),   .par_o(par_calc));

  assign syn    = par_stored ^ par_calc;
  assign erased = (&stored_code_i) && (calc_code_i == '0);

  ecc_syndrome_classify i_classify (.syn_i(syn), .erased_i(erased), .stat_o(stat_d));
  ecc_error_locate      i_locate   (.syn_i(syn), .ofs_o(ofs_raw), .mask_o(mask_raw));

  always_comb begin
    if (stat_d == ECC_FIXED) begin
      ofs_d  = ofs_raw;
      mask_d = mask_raw;
    end else begin
      ofs_d  = '0;
      mask_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ECC_CLEAN;
      ofs_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      stat_q <= stat_d;
      ofs_q  <= ofs_d;
      mask_q <= mask_d;
    end
  end

  assign done_o       = done_q;
  assign status_o     = stat_q;
  assign fix_offset_o = ofs_q;
  assign fix_mask_o   = mask_q;
endmodule

// File: rtl/ecc_sector_fixer_chk.sv
module ecc_sector_fixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [23:0] stored_code_i,
  input logic [23:0] calc_code_i,
  input logic        done_o,
  input logic [1:0]  status_o,
  input logic [8:0]  fix_offset_o,
  input logic [7:0]  fix_mask_o
);
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  a_r10_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(status_o) && $stable(fix_offset_o) && $stable(fix_mask_o)));

  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b01) |-> ($countones(fix_mask_o) == 1));

  a_r10_location_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'b01) |-> (fix_mask_o == 8'h00 && fix_offset_o == 9'd0));

  a_r3_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stored_code_i == calc_code_i) |=> (status_o == 2'b00));

  a_r8_erased_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stored_code_i == 24'hFFFFFF && calc_code_i == 24'h000000) |=> (status_o == 2'b00));

  a_r5_single_one_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && $countones(stored_code_i ^ calc_code_i) == 1) |=> (status_o == 2'b10));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!done_o && status_o == 2'b00 && fix_mask_o == 8'h00));
endmodule

bind ecc_sector_fixer ecc_sector_fixer_chk i_ecc_sector_fixer_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .stored_code_i(stored_code_i), .calc_code_i(calc_code_i),
  .done_o(done_o), .status_o(status_o),
  .fix_offset_o(fix_offset_o), .fix_mask_o(fix_mask_o)
);

// File: tb/test_ecc_sector_fixer.sv
module test_ecc_sector_fixer;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] stored_code_i;
  logic [23:0] calc_code_i;
  logic        done_o;
  logic [1:0]  status_o;
  logic [8:0]  fix_offset_o;
  logic [7:0]  fix_mask_o;

  int checks = 0;
  int errors = 0;

  ecc_sector_fixer i_ecc_sector_fixer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .stored_code_i(stored_code_i), .calc_code_i(calc_code_i),
    .done_o(done_o), .status_o(status_o),
    .fix_offset_o(fix_offset_o), .fix_mask_o(fix_mask_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Packing from the brief: {odd[11:8], even[11:8], odd[7:0], even[7:0]}
  function automatic logic [23:0] pack(input logic [11:0] ev, input logic [11:0] od);
    return {od[11:8], ev[11:8], od[7:0], ev[7:0]};
  endfunction

  // Strobe once; sample at the negedge after the capturing posedge
  task automatic run(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    stored_code_i = st;
    calc_code_i   = ca;
    start_i       = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic expect_result(input string req, input int st, input int ofs, input int msk);
    check(req, "done", int'(done_o), 1);
    check(req, "status", int'(status_o), st);
    check(req, "offset", int'(fix_offset_o), ofs);
    check(req, "mask", int'(fix_mask_o), msk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0; stored_code_i = '0; calc_code_i = '0;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", int'(done_o), 0);
    check("R1", "status in reset", int'(status_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "done", int'(done_o), 0);
    check("R1", "status", int'(status_o), 0);
    check("R1", "offset", int'(fix_offset_o), 0);
    check("R1", "mask", int'(fix_mask_o), 0);
  endtask

  task automatic t_equal;
    run(24'h123456, 24'h123456);
    expect_result("R3", 0, 0, 0);
    run(24'h000000, 24'h000000);
    expect_result("R3", 0, 0, 0);
    @(negedge clk);
    check("R2", "done drops", int'(done_o), 0);
  endtask

  task automatic t_single(input int byte_ofs, input int bit_idx, input logic [11:0] ev, input logic [11:0] od);
    logic [11:0] adr;
    adr = {byte_ofs[8:0], bit_idx[2:0]};
    run(pack(ev, od), pack(ev ^ ~adr, od ^ adr));
    expect_result("R4", 1, byte_ofs, 1 << bit_idx);
  endtask

  task automatic t_fatal_counts;
    run(24'h5A5A5A, 24'h5A5A5A ^ 24'h000001);
    expect_result("R5", 2, 0, 0);
    run(24'h0F0F0F, 24'h0F0F0F ^ 24'h800000);
    expect_result("R5", 2, 0, 0);
    run(24'h00C3A1, 24'h00C3A1 ^ 24'h0007FF);
    expect_result("R6", 2, 0, 0);
    run(24'h3C3C3C, 24'h3C3C3C ^ 24'h000003);
    expect_result("R7", 2, 0, 0);
    run(24'h123456, 24'h123456 ^ 24'hFFFFFE);
    expect_result("R7", 2, 0, 0);
  endtask

  task automatic t_erased;
    run(24'hFFFFFF, 24'h000000);
    expect_result("R8", 0, 0, 0);
    run(24'hFFFFFF, 24'h000001);
    expect_result("R9", 2, 0, 0);
    run(24'hFFFFFF, 24'h00FFFF);
    expect_result("R9", 2, 0, 0);
  endtask

  task automatic t_hold;
    logic [11:0] adr;
    adr = {9'd77, 3'd6};
    run(pack(12'h0, 12'h0), pack(~adr, adr));
    expect_result("R4", 1, 77, 8'h40);
    stored_code_i = 24'hFFFFFF; calc_code_i = 24'h000001;
    repeat (3) @(negedge clk);
    check("R10", "status held", int'(status_o), 1);
    check("R10", "offset held", int'(fix_offset_o), 77);
    check("R10", "mask held", int'(fix_mask_o), 8'h40);
    check("R2", "no done without strobe", int'(done_o), 0);
  endtask

  initial begin
    t_reset();
    t_equal();
    t_single(0, 0, 12'h000, 12'h000);
    t_single(511, 7, 12'hA5C, 12'h3F1);
    t_single(300, 5, 12'hFFF, 12'h000);
    t_single(1, 2, 12'h123, 12'h456);
    t_fatal_counts();
    t_erased();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule